// File: doc/BRIEF.md
# Three-Tier Interrupt Aggregator

This block collects interrupt events from six event-producing units and reduces them to one registered, active-high interrupt line. Five of the units form a switch group: a buffer manager, a switch engine and three port MACs. The sixth is a timestamp unit. Each unit has a sticky pending register and a mask register. A single-cycle event pulse sets a pending bit, and software clears the bit by writing 1 to it. A switch-level summary register gives one bit per switch-group unit, and a switch-level mask selects which units count. A top status register holds one summary bit for each group, and a matching top enable register gates them. The final stage ANDs the result with a global output-enable bit in a configuration register.

Software reaches every register through a simple single-port word interface. A write takes effect on the clock edge at which `wr_en` is high. Read data is registered, so `rd_data` shows the addressed word one cycle after `addr` is presented. In every mask and enable register, a 1 lets the bit pass to the tier above. Unmapped addresses read as zero.

Top module: `irq_tier_agg`

## Requirements
- R1: After synchronous reset, every pending, mask and enable bit and the output-enable bit read as zero, and `irq` is low.
- R2: A pulse on an event input sets the matching pending bit. The bit then stays set until it is cleared, whether or not it is masked. Unit s of the switch group (0 buffer manager, 1 switch engine, 2/3/4 port MAC 0/1/2) uses event input bits s*SRC_W+b, has its pending register at address 7+2s and its mask register at address 8+2s.
- R3: Writing to a pending address clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit remains set.
- R5: The switch summary register at address 5 is read-only. Its bit s is 1 exactly when unit s has a pending bit whose mask bit is 1. Writes to it have no effect.
- R6: The top status register at address 0 is read-only. Bit 28 is 1 when some switch summary bit is set and its switch mask bit (address 6, bit s) is 1. Bit 29 is 1 when some timestamp pending bit is set and its timestamp enable bit (address 4) is 1. Writes to it have no effect.
- R7: `irq` is registered. It is high in the cycle after the following both hold: configuration bit 8 (address 2) is 1, and some top status bit is 1 while the same bit of the top enable register (address 1, bits 28/29) is 1.
- R8: `irq` falls one cycle after the clearing write that removes the last enabled pending source.
- R9: Mask and enable registers read back what was written, limited to their defined bits: SRC_W bits for unit masks, 5 for the switch mask, 9 for the timestamp enable, bits 28–29 for the top enable, and bit 8 for the configuration register.
- R10: Timestamp pending (address 3, write-1-to-clear) has these bit positions. Bits 0–5 are transmit/receive captures for port 0 tx, port 0 rx, port 1 tx, port 1 rx, port 2 tx and port 2 rx. Bits 6 and 7 are the two GPIO capture inputs. Bit 8 is the timer. Each bit is set by the same-numbered bit of `ts_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_evt | input | 5*SRC_W | Event pulses of the switch-group units, unit s at bits s*SRC_W +: SRC_W |
| ts_evt | input | 9 | Event pulses of the timestamp unit |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the previous cycle's address |
| irq | output | 1 | Registered active-high interrupt output |

## Verification
For every event bit of every unit, the bench steps through all sixteen settings of unit mask, switch mask, group enable and output enable. It then checks the pending, summary, status and `irq` values against a product of those four bits. A design that gated pending capture by the mask, or skipped a tier, would show a wrong pending or summary value for some setting. The bench also targets the cases below:
- a simultaneous event and clear, where a clear-priority design loses the event;
- a partial clear, where a design that clears the whole register drops other bits;
- writes to read-only summaries;
- writes of all ones to masks, where a design that stores undefined bits reads them back.

It also checks that `irq` falls exactly one cycle after the last clear. A design with an extra register stage, or a combinational output, is caught at that point.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // number of switch-group units and timestamp sources
  localparam int NSUB = 5;
  localparam int TS_W = 9;

  // register word addresses
  localparam int A_TOP_STAT = 0;
  localparam int A_TOP_EN   = 1;
  localparam int A_CFG      = 2;
  localparam int A_TS_PEND  = 3;
  localparam int A_TS_EN    = 4;
  localparam int A_SW_SUM   = 5;
  localparam int A_SW_MASK  = 6;
  localparam int A_SUB_BASE = 7;  // unit s: pending at base+2s, mask at base+2s+1

  // bit positions with decoded meaning
  localparam int TOP_SW_BIT = 28;
  localparam int TOP_TS_BIT = 29;
  localparam int CFG_EN_BIT = 8;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] mask,
  output logic         summary
);
  logic [W-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= '0;
    end else begin
      // a new event outranks a clear of the same bit
      pend <= (pend & ~clr_bits) | evt;
      if (mask_we) mask <= wdata;
    end
  end

  assign summary = |(pend & mask);
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int SRC_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [1:0]             top_stat,
  input  logic [1:0]             top_en,
  input  logic                   irq_en,
  input  logic [TS_W-1:0]        ts_pend,
  input  logic [TS_W-1:0]        ts_en,
  input  logic [NSUB-1:0]        sw_sum,
  input  logic [NSUB-1:0]        sw_mask,
  input  logic [NSUB*SRC_W-1:0]  sub_pend_f,
  input  logic [NSUB*SRC_W-1:0]  sub_mask_f,
  output logic [DATA_W-1:0]      rd_data
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_W'(A_TOP_STAT): begin
        rd_d[TOP_SW_BIT] = top_stat[0];
        rd_d[TOP_TS_BIT] = top_stat[1];
      end
      ADDR_W'(A_TOP_EN): begin
        rd_d[TOP_SW_BIT] = top_en[0];
        rd_d[TOP_TS_BIT] = top_en[1];
      end
      ADDR_W'(A_CFG):     rd_d[CFG_EN_BIT] = irq_en;
      ADDR_W'(A_TS_PEND): rd_d[TS_W-1:0] = ts_pend;
      ADDR_W'(A_TS_EN):   rd_d[TS_W-1:0] = ts_en;
      ADDR_W'(A_SW_SUM):  rd_d[NSUB-1:0] = sw_sum;
      ADDR_W'(A_SW_MASK): rd_d[NSUB-1:0] = sw_mask;
      default: ;
    endcase
    for (int s = 0; s < NSUB; s++) begin
      if (addr == ADDR_W'(A_SUB_BASE + 2*s))
        rd_d[SRC_W-1:0] = sub_pend_f[s*SRC_W +: SRC_W];
      if (addr == ADDR_W'(A_SUB_BASE + 2*s + 1))
        rd_d[SRC_W-1:0] = sub_mask_f[s*SRC_W +: SRC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end
endmodule

// File: rtl/irq_tier_agg.sv
module irq_tier_agg
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int SRC_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSUB*SRC_W-1:0] sub_evt,
  input  logic [TS_W-1:0]       ts_evt,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  irq
);
  logic [NSUB*SRC_W-1:0] sub_pend_f;
  logic [NSUB*SRC_W-1:0] sub_mask_f;
  logic [NSUB-1:0]       sw_sum;
  logic [NSUB-1:0]       sw_mask_q;
  logic [TS_W-1:0]       ts_pend;
  logic [TS_W-1:0]       ts_en;
  logic                  ts_sum;
  logic [1:0]            top_en_q;   // [0] switch group, [1] timestamp group
  logic [1:0]            top_stat;
  logic                  irq_en_q;

  // lowest tier: switch-group units
  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    logic clr_hit, mask_hit;
    assign clr_hit  = wr_en && (addr == ADDR_W'(A_SUB_BASE + 2*s));
    assign mask_hit = wr_en && (addr == ADDR_W'(A_SUB_BASE + 2*s + 1));
    irq_pend_bank #(.W(SRC_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .evt     (sub_evt[s*SRC_W +: SRC_W]),
      .clr_we  (clr_hit),
      .mask_we (mask_hit),
      .wdata   (wdata[SRC_W-1:0]),
      .pend    (sub_pend_f[s*SRC_W +: SRC_W]),
      .mask    (sub_mask_f[s*SRC_W +: SRC_W]),
      .summary (sw_sum[s])
    );
  end

  // lowest tier: timestamp unit (enable register acts as its mask)
  irq_pend_bank #(.W(TS_W)) u_ts_bank (
    .clk     (clk),
    .rst     (rst),
    .evt     (ts_evt),
    .clr_we  (wr_en && (addr == ADDR_W'(A_TS_PEND))),
    .mask_we (wr_en && (addr == ADDR_W'(A_TS_EN))),
    .wdata   (wdata[TS_W-1:0]),
    .pend    (ts_pend),
    .mask    (ts_en),
    .summary (ts_sum)
  );

  // middle and top tiers, output stage
  assign top_stat = {ts_sum, |(sw_sum & sw_mask_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_mask_q <= '0;
      top_en_q  <= '0;
      irq_en_q  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_en && addr == ADDR_W'(A_SW_MASK)) sw_mask_q <= wdata[NSUB-1:0];
      if (wr_en && addr == ADDR_W'(A_TOP_EN))
        top_en_q <= {wdata[TOP_TS_BIT], wdata[TOP_SW_BIT]};
      if (wr_en && addr == ADDR_W'(A_CFG)) irq_en_q <= wdata[CFG_EN_BIT];
      irq <= irq_en_q && (|(top_stat & top_en_q));
    end
  end

  irq_agg_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_rdmux (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .top_stat   (top_stat),
    .top_en     (top_en_q),
    .irq_en     (irq_en_q),
    .ts_pend    (ts_pend),
    .ts_en      (ts_en),
    .sw_sum     (sw_sum),
    .sw_mask    (sw_mask_q),
    .sub_pend_f (sub_pend_f),
    .sub_mask_f (sub_mask_f),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/irq_tier_agg_chk.sv
module irq_tier_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              irq_en,
  input logic [1:0]        top_stat,
  input logic [1:0]        top_en,
  input logic [TS_W-1:0]   ts_evt,
  input logic [TS_W-1:0]   ts_pend,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr
);
  logic ts_clr;
  assign ts_clr = wr_en && (addr == ADDR_W'(A_TS_PEND));

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en)); // R7

  AST_IRQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(top_stat & top_en))); // R7

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(irq_en && (|(top_stat & top_en))))); // R8

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(ts_clr)) |-> ((ts_pend & $past(ts_pend)) == $past(ts_pend))); // R2

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ts_pend & $past(ts_evt)) == $past(ts_evt))); // R4
endmodule

bind irq_tier_agg irq_tier_agg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .irq_en   (irq_en_q),
  .top_stat (top_stat),
  .top_en   (top_en_q),
  .ts_evt   (ts_evt),
  .ts_pend  (ts_pend),
  .wr_en    (wr_en),
  .addr     (addr)
);

// File: tb/tb_irq_tier_agg.sv
module tb_irq_tier_agg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int SRC_W  = 4;
  localparam int NSUB   = 5;
  localparam int TS_W   = 9;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [NSUB*SRC_W-1:0] sub_evt = '0;
  logic [TS_W-1:0]       ts_evt = '0;
  logic                  wr_en = 1'b0;
  logic [ADDR_W-1:0]     addr = '0;
  logic [DATA_W-1:0]     wdata = '0;
  logic [DATA_W-1:0]     rd_data;
  logic                  irq;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_tier_agg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)) dut (
    .clk(clk), .rst(rst), .sub_evt(sub_evt), .ts_evt(ts_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = ADDR_W'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state of every address and the output
    check("R1 irq", {31'b0, irq}, 32'd0);
    for (int a = 0; a < 17; a++) begin
      rd(a, v);
      check($sformatf("R1 addr %0d", a), v, 32'd0);
    end

    // R9: read-back limited to defined bits
    wr(8, 32'hFFFF_FFFF);  rd(8, v);  check("R9 unit mask", v, 32'h0000_000F);
    wr(6, 32'hFFFF_FFFF);  rd(6, v);  check("R9 switch mask", v, 32'h0000_001F);
    wr(4, 32'hFFFF_FFFF);  rd(4, v);  check("R9 ts enable", v, 32'h0000_01FF);
    wr(1, 32'hFFFF_FFFF);  rd(1, v);  check("R9 top enable", v, 32'h3000_0000);
    wr(2, 32'hFFFF_FFFF);  rd(2, v);  check("R9 config", v, 32'h0000_0100);
    wr(8, 0); wr(6, 0); wr(4, 0); wr(1, 0); wr(2, 0);

    // R5, R6: writes to read-only summaries have no effect
    wr(0, 32'hFFFF_FFFF);  rd(0, v);  check("R6 top status ro", v, 32'd0);
    wr(5, 32'hFFFF_FFFF);  rd(5, v);  check("R5 switch summary ro", v, 32'd0);

    // R3: partial clear on unit 1 (events at bits 1*4+0 and 1*4+2)
    sub_evt = 20'h00050;
    @(negedge clk); sub_evt = '0;
    rd(9, v);  check("R3 before clear", v, 32'h5);
    wr(9, 32'h1);
    rd(9, v);  check("R3 partial clear", v, 32'h4);
    wr(9, 32'h4);
    rd(9, v);  check("R3 full clear", v, 32'h0);

    // R4: event and clear of the same bit in one cycle
    sub_evt = 20'h00002; wr_en = 1'b1; addr = 5'd7; wdata = 32'h2;
    @(negedge clk);
    sub_evt = '0; wr_en = 1'b0; wdata = '0;
    rd(7, v);  check("R4 event beats clear", v, 32'h2);
    wr(7, 32'h2);
    rd(7, v);  check("R4 cleared afterwards", v, 32'h0);

    // R2, R5, R6, R7, R8: sweep switch-group units, bits and gate settings
    for (int s = 0; s < NSUB; s++) begin
      for (int b = 0; b < SRC_W; b++) begin
        for (int g = 0; g < 16; g++) begin
          logic m0, m1, m2, m3, exp_irq;
          m0 = g[0]; m1 = g[1]; m2 = g[2]; m3 = g[3];
          exp_irq = m0 & m1 & m2 & m3;
          wr(8 + 2*s, m0 ? (32'd1 << b) : 32'd0);
          wr(6, m1 ? (32'd1 << s) : 32'd0);
          wr(1, m2 ? 32'h1000_0000 : 32'd0);
          wr(2, m3 ? 32'h0000_0100 : 32'd0);
          sub_evt[s*SRC_W + b] = 1'b1;
          @(negedge clk);
          sub_evt = '0;
          @(negedge clk);
          check("R7 irq asserted per gates", {31'b0, irq}, {31'b0, exp_irq});
          rd(7 + 2*s, v); check("R2 pending sticky", v, 32'd1 << b);
          rd(5, v);       check("R5 switch summary", v, m0 ? (32'd1 << s) : 32'd0);
          rd(0, v);       check("R6 top status bit 28", v, (m0 & m1) ? 32'h1000_0000 : 32'd0);
          check("R7 irq held", {31'b0, irq}, {31'b0, exp_irq});
          wr(7 + 2*s, 32'd1 << b);
          check("R8 irq one cycle after clear", {31'b0, irq}, {31'b0, exp_irq});
          @(negedge clk);
          check("R8 irq low after clear", {31'b0, irq}, 32'd0);
          rd(7 + 2*s, v); check("R3 pending cleared", v, 32'd0);
        end
        wr(8 + 2*s, 0);
      end
    end
    wr(6, 0); wr(1, 0); wr(2, 0);

    // R10, R6, R7, R8: timestamp sources
    for (int b = 0; b < TS_W; b++) begin
      for (int g = 0; g < 8; g++) begin
        logic e0, e1, e2, exp_irq;
        e0 = g[0]; e1 = g[1]; e2 = g[2];
        exp_irq = e0 & e1 & e2;
        wr(4, e0 ? (32'd1 << b) : 32'd0);
        wr(1, e1 ? 32'h2000_0000 : 32'd0);
        wr(2, e2 ? 32'h0000_0100 : 32'd0);
        ts_evt[b] = 1'b1;
        @(negedge clk);
        ts_evt = '0;
        @(negedge clk);
        check("R7 ts irq", {31'b0, irq}, {31'b0, exp_irq});
        rd(3, v); check("R10 ts pending position", v, 32'd1 << b);
        rd(0, v); check("R6 top status bit 29", v, e0 ? 32'h2000_0000 : 32'd0);
        wr(3, 32'd1 << b);
        @(negedge clk);
        check("R8 ts irq low after clear", {31'b0, irq}, 32'd0);
        rd(3, v); check("R10 ts pending cleared", v, 32'd0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule